// File: doc/BRIEF.md
# Prescaled Up-Counter Timer with Output-Compare Channel

This block is a memory-mapped 32-bit timer. An up-counter advances once per prescaled tick. The tick rate is the clock divided by a power of two that software selects. The counter wraps to zero after it reaches a programmable ceiling, so with the ceiling at all ones it runs freely over the whole 32-bit range.

A single output-compare channel watches the counter. When the counter steps into the channel's value while the channel is armed in software-compare mode, a sticky flag is set. If the channel's interrupt enable is set, the flag drives a level interrupt. Software clears the flag by writing a one to it.

Software reaches the block over a plain single-cycle register bus made of an address, a write strobe, write data and combinational read data. A typical use is a one-shot event source. Software reads the count, adds a delta, writes the sum as the compare value, and waits for the interrupt.

Top module: `cmp_timer`

## Requirements
- R1: After reset, every register reads zero except the ceiling register (offset 0x18), which reads 0xFFFFFFFF. Reads of offsets that map to no register return zero. The other offsets are: control 0x10, count 0x14, status 0x1C, channel control 0x20, channel value 0x24. Control reads back bits [4:0], channel control reads back bits [6:2], and all other bits of both read zero.
- R2: When control bits [4:3] equal 2'b01, the count increases by one every 2^N clocks, where N is control bits [2:0]. After a control write that starts counting from a halted state, the first increment lands exactly 2^N clock edges after the write edge.
- R3: When control bits [4:3] are not 2'b01, the count holds its value. Writing zero to control therefore stops it.
- R4: On a tick while the count equals the ceiling register, the count becomes zero.
- R5: A write of any value to the count register sets the count to zero. This write takes priority over a tick in the same cycle.
- R6: When channel control bits [5:2] equal 4 and the counter advances into a value equal to the channel value register, status bit 0 (the flag) is set at that same edge. This includes a wrap into zero.
- R7: The flag stays set until a status write with bit 0 equal to 1 clears it. A write with bit 0 equal to 0 leaves it unchanged. A match in the same cycle as a clear leaves the flag set.
- R8: The interrupt output is high exactly while the flag is set and channel control bit 6 (interrupt enable) is 1. A match with the enable at 0 sets the flag but not the interrupt.
- R9: While channel control bits [5:2] differ from 4, no match sets the flag.
- R10: Every write to the control register restarts the prescaler. The next increment therefore comes a full 2^N edges after that write, even when the field value is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (8) | Register byte offset |
| wr_en_i | input | 1 | Write strobe, one write per asserted cycle |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Combinational read data for addr_i |
| irq_o | output | 1 | Level interrupt: flag AND interrupt enable |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath and a 3-bit prescale field. With these, divisors of 1, 8 and 32 can be checked exactly within a few hundred cycles. Small ceiling values such as 5 bring the wrap, and a compare match on the wrap into zero, within a handful of ticks. The full-range reset value of the ceiling is checked only at reset.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  // register byte offsets (software decodes these)
  localparam int OFF_CTRL  = 'h10;
  localparam int OFF_COUNT = 'h14;
  localparam int OFF_CEIL  = 'h18;
  localparam int OFF_STAT  = 'h1C;
  localparam int OFF_CHCTL = 'h20;
  localparam int OFF_CHVAL = 'h24;

  // field positions
  localparam int CTRL_SEL_LSB  = 0;
  localparam int CTRL_MODE_LSB = 3;
  localparam int CTRL_MODE_W   = 2;
  localparam int CH_MODE_LSB   = 2;
  localparam int CH_MODE_W     = 4;
  localparam int CH_IE_BIT     = 6;

  localparam logic [CTRL_MODE_W-1:0] CLK_MODE_PRESCALED = 2'b01;
  localparam logic [CH_MODE_W-1:0]   CH_MODE_SWCMP      = 4'd4;
endpackage

// File: rtl/cmp_timer_prescaler.sv
module cmp_timer_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] div_cnt;

  // last phase of a 2^sel divide
  function automatic logic [CNT_W-1:0] last_phase(input logic [SEL_W-1:0] s);
    return (CNT_W'(1) << s) - CNT_W'(1);
  endfunction

  assign tick = run && !restart && (div_cnt == last_phase(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 div_cnt <= '0;
    else if (restart || !run)   div_cnt <= '0;
    else if (tick)              div_cnt <= '0;
    else                        div_cnt <= div_cnt + CNT_W'(1);
  end
endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  input  logic         clear,
  input  logic [W-1:0] ceil,
  output logic [W-1:0] cnt,
  output logic [W-1:0] next_cnt
);
  function automatic logic [W-1:0] step(input logic [W-1:0] c, input logic [W-1:0] top);
    return (c == top) ? '0 : c + W'(1);
  endfunction

  assign next_cnt = step(cnt, ceil);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (advance) cnt <= next_cnt;
  end
endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel #(
  parameter int W      = 32,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic [W-1:0]      next_cnt,
  input  logic [W-1:0]      match_val,
  input  logic [MODE_W-1:0] mode,
  input  logic              ie,
  input  logic              flag_clr,
  output logic              cmp_en,
  output logic              match_evt,
  output logic              flag,
  output logic              irq
);
  assign cmp_en    = (mode == cmp_timer_pkg::CH_MODE_SWCMP);
  assign match_evt = advance && cmp_en && (next_cnt == match_val);
  assign irq       = flag && ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (match_evt) flag <= 1'b1;
    else if (flag_clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  import cmp_timer_pkg::*;

  localparam int CTRL_W = SEL_W + CTRL_MODE_W;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_CEIL  = ADDR_W'(OFF_CEIL);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CHCTL = ADDR_W'(OFF_CHCTL);
  localparam logic [ADDR_W-1:0] A_CHVAL = ADDR_W'(OFF_CHVAL);

  logic [SEL_W-1:0]       sel_q;
  logic [CTRL_MODE_W-1:0] clkmode_q;
  logic [DATA_W-1:0]      ceil_q, chval_q, cnt_q, next_cnt;
  logic [CH_MODE_W-1:0]   chmode_q;
  logic                   ie_q;

  // named internal events
  logic ctrl_wr, cnt_clr, flag_clr, run, tick, advance;
  logic cmp_en, match_evt, flag;
  logic unused_wdata;

  assign ctrl_wr  = wr_en_i && (addr_i == A_CTRL);
  assign cnt_clr  = wr_en_i && (addr_i == A_COUNT);
  assign flag_clr = wr_en_i && (addr_i == A_STAT) && wdata_i[0];
  assign run      = (clkmode_q == CLK_MODE_PRESCALED);
  assign advance  = tick && !cnt_clr;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      clkmode_q <= '0;
      ceil_q    <= '1;
      chval_q   <= '0;
      chmode_q  <= '0;
      ie_q      <= 1'b0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        A_CTRL: begin
          sel_q     <= wdata_i[CTRL_SEL_LSB +: SEL_W];
          clkmode_q <= wdata_i[CTRL_MODE_LSB +: CTRL_MODE_W];
        end
        A_CEIL:  ceil_q  <= wdata_i;
        A_CHVAL: chval_q <= wdata_i;
        A_CHCTL: begin
          chmode_q <= wdata_i[CH_MODE_LSB +: CH_MODE_W];
          ie_q     <= wdata_i[CH_IE_BIT];
        end
        default: ;
      endcase
    end
  end

  cmp_timer_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(ctrl_wr),
    .sel(sel_q), .tick(tick)
  );

  cmp_timer_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .advance(advance), .clear(cnt_clr),
    .ceil(ceil_q), .cnt(cnt_q), .next_cnt(next_cnt)
  );

  cmp_timer_channel #(.W(DATA_W), .MODE_W(CH_MODE_W)) u_ch (
    .clk(clk), .rst_n(rst_n), .advance(advance), .next_cnt(next_cnt),
    .match_val(chval_q), .mode(chmode_q), .ie(ie_q), .flag_clr(flag_clr),
    .cmp_en(cmp_en), .match_evt(match_evt), .flag(flag), .irq(irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[CTRL_SEL_LSB +: SEL_W]        = sel_q;
        rdata_o[CTRL_MODE_LSB +: CTRL_MODE_W] = clkmode_q;
      end
      A_COUNT: rdata_o = cnt_q;
      A_CEIL:  rdata_o = ceil_q;
      A_STAT:  rdata_o[0] = flag;
      A_CHCTL: begin
        rdata_o[CH_MODE_LSB +: CH_MODE_W] = chmode_q;
        rdata_o[CH_IE_BIT]                = ie_q;
      end
      A_CHVAL: rdata_o = chval_q;
      default: ;
    endcase
  end

  if (CTRL_W > DATA_W) begin : g_bad_width
    initial $display("cmp_timer: control field wider than data bus");
  end
endmodule

// File: rtl/cmp_timer_sva.sv
module cmp_timer_sva #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         tick,
  input logic         cnt_clr,
  input logic         advance,
  input logic [W-1:0] cnt,
  input logic [W-1:0] ceil,
  input logic         match_evt,
  input logic         flag,
  input logic         flag_clr,
  input logic         cmp_en,
  input logic         irq
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && cnt != ceil) |=> cnt == $past(cnt) + W'(1));             // R2
  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);                                                        // R2
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_clr) |=> $stable(cnt));                                 // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && cnt == ceil) |=> cnt == '0);                              // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> cnt == '0);                                               // R5
  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag);                                                  // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);                                        // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> flag);                                                 // R8
  AST_FLAG_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(cmp_en));                                       // R9
endmodule

bind cmp_timer cmp_timer_sva #(.W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cnt_clr(cnt_clr),
  .advance(advance), .cnt(cnt_q), .ceil(ceil_q), .match_evt(match_evt),
  .flag(flag), .flag_clr(flag_clr), .cmp_en(cmp_en), .irq(irq_o)
);

// File: tb/cmp_timer_bench.sv
`timescale 1ns/1ps
module cmp_timer_bench;
  localparam logic [7:0] A_CTRL = 8'h10, A_COUNT = 8'h14, A_CEIL = 8'h18,
                         A_STAT = 8'h1C, A_CHCTL = 8'h20, A_CHVAL = 8'h24;
  localparam logic [31:0] RUN = 32'h08;          // clock mode 01
  localparam logic [31:0] CH_CMP_IE = 32'h50;    // mode 4, enable
  localparam logic [31:0] CH_CMP    = 32'h10;    // mode 4, no enable

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmp_timer u_cmp_timer (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // entry point of every task is just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.1;
    d = rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  // halt, clear flag and count, restore channel defaults
  task automatic prepare();
    wr(A_CTRL, 32'h0);
    wr(A_CHCTL, 32'h0);
    wr(A_STAT, 32'h1);
    wr(A_COUNT, 32'h0);
    wr(A_CEIL, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    check_reg("R1 ctrl", A_CTRL, 32'h0);
    check_reg("R1 count", A_COUNT, 32'h0);
    check_reg("R1 ceil", A_CEIL, 32'hFFFF_FFFF);
    check_reg("R1 status", A_STAT, 32'h0);
    check_reg("R1 chctl", A_CHCTL, 32'h0);
    check_reg("R1 chval", A_CHVAL, 32'h0);
    check_reg("R1 unmapped", 8'h00, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'hFFFF_FFFF);
    check_reg("R1 ctrl readback", A_CTRL, 32'h1F);
    wr(A_CHCTL, 32'hFFFF_FFFF);
    check_reg("R1 chctl readback", A_CHCTL, 32'h7C);
    wr(A_CHVAL, 32'hDEAD_BEEF);
    check_reg("R1 unmapped 0x28", 8'h28, 32'h0);
  endtask

  task automatic t_prescale(input int sel, input int n);
    int d;
    d = 1 << sel;
    prepare();
    wr(A_CTRL, RUN | sel);
    edges(d - 1);
    check_reg($sformatf("R2 div%0d before first", d), A_COUNT, 32'h0);
    edges(1);
    check_reg($sformatf("R2 div%0d first", d), A_COUNT, 32'h1);
    edges(n * d - d);
    check_reg($sformatf("R2 div%0d after %0d", d, n), A_COUNT, n);
  endtask

  task automatic t_halt();
    prepare();
    wr(A_CTRL, RUN);
    edges(6);
    wr(A_CTRL, 32'h0);
    check_reg("R3 halted value", A_COUNT, 32'd6);
    edges(20);
    check_reg("R3 still halted", A_COUNT, 32'd6);
    wr(A_CTRL, 32'h18);        // clock mode 11: not counting
    edges(10);
    check_reg("R3 other mode", A_COUNT, 32'd6);
  endtask

  task automatic t_wrap();
    prepare();
    wr(A_CEIL, 32'd5);
    wr(A_CTRL, RUN);
    edges(4);
    check_reg("R4 below ceiling", A_COUNT, 32'd4);
    edges(2);
    check_reg("R4 wrapped", A_COUNT, 32'd0);
    edges(2);
    check_reg("R4 after wrap", A_COUNT, 32'd2);
  endtask

  task automatic t_clear();
    prepare();
    wr(A_COUNT, 32'h0);
    wr(A_CTRL, RUN);
    edges(9);
    wr(A_COUNT, 32'h1234_5678);
    check_reg("R5 cleared while running", A_COUNT, 32'h0);
    wr(A_CTRL, 32'h0);
    wr(A_COUNT, 32'hFFFF_FFFF);
    check_reg("R5 cleared while halted", A_COUNT, 32'h0);
  endtask

  task automatic t_match();
    prepare();
    wr(A_CHVAL, 32'd10);
    wr(A_CHCTL, CH_CMP_IE);
    wr(A_CTRL, RUN);
    edges(9);
    check_reg("R6 before match", A_STAT, 32'h0);
    check("R8 irq before match", {31'b0, irq}, 32'h0);
    edges(1);
    check_reg("R6 count at match", A_COUNT, 32'd10);
    check_reg("R6 flag at match", A_STAT, 32'h1);
    check("R8 irq at match", {31'b0, irq}, 32'h1);
    edges(15);
    check_reg("R7 sticky", A_STAT, 32'h1);
    wr(A_STAT, 32'hFFFF_FFFE);
    check_reg("R7 write 0 ignored", A_STAT, 32'h1);
    check("R7 irq kept", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h1);
    check_reg("R7 write 1 clears", A_STAT, 32'h0);
    check("R8 irq drops", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_match_div();
    prepare();
    wr(A_CHVAL, 32'd3);
    wr(A_CHCTL, CH_CMP_IE);
    wr(A_CTRL, RUN | 32'd2);
    edges(11);
    check_reg("R6 div4 edge 11", A_STAT, 32'h0);
    edges(1);
    check_reg("R6 div4 edge 12", A_STAT, 32'h1);
  endtask

  task automatic t_match_wrap();
    prepare();
    wr(A_CEIL, 32'd5);
    wr(A_CHVAL, 32'd0);
    wr(A_CHCTL, CH_CMP_IE);
    wr(A_CTRL, RUN);
    edges(5);
    check_reg("R6 wrap pending", A_STAT, 32'h0);
    edges(1);
    check_reg("R6 wrap count", A_COUNT, 32'h0);
    check_reg("R6 wrap match", A_STAT, 32'h1);
  endtask

  task automatic t_gate();
    prepare();
    wr(A_CHVAL, 32'd4);
    wr(A_CHCTL, CH_CMP);
    wr(A_CTRL, RUN);
    edges(6);
    check_reg("R8 flag without enable", A_STAT, 32'h1);
    check("R8 irq masked", {31'b0, irq}, 32'h0);
    wr(A_CHCTL, CH_CMP_IE);
    check("R8 irq on enable", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_disabled();
    prepare();
    wr(A_CHVAL, 32'd3);
    wr(A_CHCTL, 32'h48);       // enable with mode 2
    wr(A_CTRL, RUN);
    edges(8);
    check_reg("R9 mode 2 no flag", A_STAT, 32'h0);
    check("R9 mode 2 no irq", {31'b0, irq}, 32'h0);
    wr(A_CHCTL, 32'h0);
    wr(A_STAT, 32'h1);
    wr(A_COUNT, 32'h0);
    edges(8);
    check_reg("R9 disabled no flag", A_STAT, 32'h0);
  endtask

  task automatic t_restart();
    prepare();
    wr(A_CTRL, RUN | 32'd3);
    edges(5);
    wr(A_CTRL, RUN | 32'd3);
    edges(7);
    check_reg("R10 restarted, not yet", A_COUNT, 32'h0);
    edges(1);
    check_reg("R10 restarted, full period", A_COUNT, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale(0, 7);
    t_prescale(3, 4);
    t_prescale(5, 3);
    t_halt();
    t_wrap();
    t_clear();
    t_match();
    t_match_div();
    t_match_wrap();
    t_gate();
    t_disabled();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule